// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry and Return

This block is the register storage of a 32-bit processor core. It keeps every physical general register and every status word, and shows software a window of sixteen general registers, chosen by the mode field of the current status word. Two combinational read ports and one write port serve the datapath. The program counter is the sixteenth visible register, and all modes share it.

An exception request names a target mode and a vector address. In one clock edge the block saves the return address (program counter plus four) in the target mode's link register. It copies the current status word into the target mode's saved status word, switches the mode, masks interrupts and loads the vector into the program counter. A return request copies the current mode's saved status word back into the current status word. A status-write port lets privileged code set the whole status word, for example to move into system mode. Unprivileged code can change only the condition flags.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word is 0x000000D3 (supervisor mode, IRQ mask bit 7 set, FIQ mask bit 6 set, all flags clear). The program counter and every general register read 0.
- R2: The mode field is status bits [4:0]. The encodings are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. Indices 0-7 and index 15 (the program counter) always map to the shared registers. In FIQ mode, indices 8-14 map to private FIQ copies. In IRQ, supervisor, abort and undefined modes, only indices 13 and 14 map to that mode's own copies. User and system modes use the shared set.
- R3: A write-port write updates the mapped register at the next clock edge. It is dropped in a cycle where an exception entry is accepted.
- R4: An accepted exception entry completes in one edge. The target mode's index-14 register receives the old program counter plus 4. Its saved status word receives the old status word. The status mode field becomes the target mode, status bit 7 is set, and the program counter becomes the vector.
- R5: Status bit 6 (FIQ mask) is set on entry to FIQ mode. Entry to any other mode leaves it unchanged. Flags and bit 5 are kept in both cases.
- R6: An exception request whose target is user, system or an unlisted encoding is ignored, and the other inputs act as if it were absent.
- R7: The saved-status output shows the current mode's saved status word, and shows 0 in user, system and unlisted modes. A return request in FIQ, IRQ, supervisor, abort or undefined mode loads the status word from it at the next edge.
- R8: A return request in user, system or an unlisted mode leaves the status word unchanged. It still blocks a status write in the same cycle.
- R9: A status write, when neither an accepted exception nor a return request is present, replaces the whole status word in a privileged mode (any listed mode except user). In user mode or an unlisted mode it replaces only bits [31:27].
- R10: An unlisted mode encoding maps registers as user mode, and the error output is high exactly while the status mode field is unlisted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register index |
| wr_data | input | 32 | Write port data |
| sr_wr_en | input | 1 | Status word write enable |
| sr_wr_data | input | 32 | Status word write value |
| exc_req | input | 1 | Exception entry request |
| exc_mode | input | 5 | Exception target mode encoding |
| exc_vector | input | 32 | Exception vector address |
| ret_req | input | 1 | Return request (restore status word) |
| status_out | output | 32 | Current status word |
| saved_status_out | output | 32 | Saved status word of the current mode |
| pc_out | output | 32 | Program counter |
| mode_err | output | 1 | Current mode encoding is unlisted |

## Verification
On every cycle the assertions check the following:
- the outcome of an accepted exception entry (mode, IRQ mask, vector, saved status word and link register seen on port A);
- the FIQ-mask rule;
- that rejected exception targets and unprivileged returns leave the status word alone;
- the restore value;
- the flag-only status write in user mode;
- the error flag.

Register banking itself is shown only by the bench's scenarios. These write distinct values in one mode and read them back in others, including FIQ's private R8-R12. A reference model compares all outputs against the design under random sequences of writes, mode changes, entries and returns.

// File: rtl/banked_regfile.sv
module banked_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd_a_idx,
  output logic [31:0] rd_a_data,
  input  logic [3:0]  rd_b_idx,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        sr_wr_en,
  input  logic [31:0] sr_wr_data,
  input  logic        exc_req,
  input  logic [4:0]  exc_mode,
  input  logic [31:0] exc_vector,
  input  logic        ret_req,
  output logic [31:0] status_out,
  output logic [31:0] saved_status_out,
  output logic [31:0] pc_out,
  output logic        mode_err
);
  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
                         M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F;
  localparam logic [2:0] C_U = 3'd0, C_F = 3'd1, C_I = 3'd2, C_S = 3'd3, C_A = 3'd4, C_D = 3'd5;
  localparam logic [31:0] RESET_SR = 32'h0000_00D3;

  logic [31:0] ur [0:15];
  logic [31:0] fq [0:6];
  logic [31:0] b13 [0:3];
  logic [31:0] b14 [0:3];
  logic [31:0] sp_b [0:3];
  logic [31:0] sp_f;
  logic [31:0] cpsr;

  function automatic logic [2:0] mclass(input logic [4:0] m);
    case (m)
      M_FIQ:   mclass = C_F;
      M_IRQ:   mclass = C_I;
      M_SVC:   mclass = C_S;
      M_ABT:   mclass = C_A;
      M_UND:   mclass = C_D;
      default: mclass = C_U;
    endcase
  endfunction

  function automatic logic mlisted(input logic [4:0] m);
    mlisted = (m == M_USR) || (m == M_SYS) || (mclass(m) != C_U);
  endfunction

  wire [2:0] cur   = mclass(cpsr[4:0]);
  wire [1:0] bsel  = 2'(cur - C_I);
  wire       priv  = (cur != C_U) || (cpsr[4:0] == M_SYS);
  wire [2:0] tcls  = mclass(exc_mode);
  wire [1:0] tsel  = 2'(tcls - C_I);
  wire       exc_go = exc_req && (tcls != C_U);
  wire [31:0] ret_addr = ur[15] + 32'd4;

  function automatic logic [31:0] rd_map(input logic [3:0] i);
    if (i >= 4'd8 && i <= 4'd14 && cur == C_F)
      rd_map = fq[i[2:0]];
    else if (i == 4'd13 && cur >= C_I)
      rd_map = b13[bsel];
    else if (i == 4'd14 && cur >= C_I)
      rd_map = b14[bsel];
    else
      rd_map = ur[i];
  endfunction

  always_comb begin
    rd_a_data = rd_map(rd_a_idx);
    rd_b_data = rd_map(rd_b_idx);
    if (cur == C_F)       saved_status_out = sp_f;
    else if (cur >= C_I)  saved_status_out = sp_b[bsel];
    else                  saved_status_out = 32'd0;
  end

  assign status_out = cpsr;
  assign pc_out     = ur[15];
  assign mode_err   = !mlisted(cpsr[4:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) ur[k] <= '0;
      for (int k = 0; k < 7; k++)  fq[k] <= '0;
      for (int k = 0; k < 4; k++) begin
        b13[k]  <= '0;
        b14[k]  <= '0;
        sp_b[k] <= '0;
      end
      sp_f <= '0;
      cpsr <= RESET_SR;
    end else if (exc_go) begin
      if (tcls == C_F) begin
        fq[6] <= ret_addr;
        sp_f  <= cpsr;
      end else begin
        b14[tsel]  <= ret_addr;
        sp_b[tsel] <= cpsr;
      end
      cpsr   <= {cpsr[31:8], 1'b1, cpsr[6] | (tcls == C_F), cpsr[5], exc_mode};
      ur[15] <= exc_vector;
    end else begin
      if (wr_en) begin
        if (wr_idx >= 4'd8 && wr_idx <= 4'd14 && cur == C_F)
          fq[wr_idx[2:0]] <= wr_data;
        else if (wr_idx == 4'd13 && cur >= C_I)
          b13[bsel] <= wr_data;
        else if (wr_idx == 4'd14 && cur >= C_I)
          b14[bsel] <= wr_data;
        else
          ur[wr_idx] <= wr_data;
      end
      if (ret_req) begin
        if (cur != C_U) cpsr <= saved_status_out;
      end else if (sr_wr_en) begin
        cpsr <= priv ? sr_wr_data : {sr_wr_data[31:27], cpsr[26:0]};
      end
    end
  end
endmodule

module banked_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        sr_wr_en,
  input logic        exc_req,
  input logic [4:0]  exc_mode,
  input logic [31:0] exc_vector,
  input logic        ret_req,
  input logic [31:0] status_out,
  input logic [31:0] saved_status_out,
  input logic [31:0] pc_out,
  input logic        mode_err
);
  function automatic logic has_saved(input logic [4:0] m);
    has_saved = (m == 5'h11) || (m == 5'h12) || (m == 5'h13) || (m == 5'h17) || (m == 5'h1B);
  endfunction

  wire tgt_ok = exc_req && has_saved(exc_mode);
  wire listed = has_saved(status_out[4:0]) || status_out[4:0] == 5'h10 || status_out[4:0] == 5'h1F;

  a_r4_exc_entry: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_ok |=> (status_out[4:0] == $past(exc_mode)) && status_out[7] &&
               (pc_out == $past(exc_vector)) && (saved_status_out == $past(status_out)));
  a_r4_exc_link: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_ok |=> (rd_a_idx != 4'd14) || (rd_a_data == $past(pc_out) + 32'd4));
  a_r5_fiq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_ok && exc_mode == 5'h11) |=> status_out[6]);
  a_r5_keep_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_ok && exc_mode != 5'h11) |=> status_out[6] == $past(status_out[6]));
  a_r6_bad_target: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !tgt_ok && !ret_req && !sr_wr_en) |=> $stable(status_out));
  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_ok && ret_req && has_saved(status_out[4:0])) |=> status_out == $past(saved_status_out));
  a_r7_no_saved: assert property (@(posedge clk) disable iff (!rst_n)
    !has_saved(status_out[4:0]) |-> saved_status_out == 32'd0);
  a_r8_restore_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_ok && ret_req && !has_saved(status_out[4:0])) |=> $stable(status_out));
  a_r9_user_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_ok && !ret_req && sr_wr_en && (status_out[4:0] == 5'h10 || !listed))
      |=> status_out[26:0] == $past(status_out[26:0]));
  a_r10_err: assert property (@(posedge clk) disable iff (!rst_n) mode_err == !listed);
endmodule

bind banked_regfile banked_regfile_chk u_chk (.*);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, sr_wr_data = 0, exc_vector = 0;
  logic wr_en = 0, sr_wr_en = 0, exc_req = 0, ret_req = 0, mode_err;
  logic [4:0] exc_mode = 0;
  logic [31:0] status_out, saved_status_out, pc_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  banked_regfile dut (.*);

  logic [31:0] m_u [16];
  logic [31:0] m_f [7];
  logic [31:0] m_b13 [4];
  logic [31:0] m_b14 [4];
  logic [31:0] m_sb [4];
  logic [31:0] m_sf, m_cp;

  function automatic int cls(input logic [4:0] m);
    case (m)
      5'h11: return 1; 5'h12: return 2; 5'h13: return 3;
      5'h17: return 4; 5'h1B: return 5; default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input int i);
    int c = cls(m_cp[4:0]);
    if (c == 1 && i >= 8 && i <= 14) return m_f[i-8];
    if (c >= 2 && i == 13) return m_b13[c-2];
    if (c >= 2 && i == 14) return m_b14[c-2];
    return m_u[i];
  endfunction

  function automatic logic [31:0] m_saved();
    int c = cls(m_cp[4:0]);
    if (c == 1) return m_sf;
    if (c >= 2) return m_sb[c-2];
    return 32'd0;
  endfunction

  function automatic logic m_err();
    return cls(m_cp[4:0]) == 0 && m_cp[4:0] != 5'h10 && m_cp[4:0] != 5'h1F;
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 16; k++) m_u[k] = 0;
    for (int k = 0; k < 7; k++) m_f[k] = 0;
    for (int k = 0; k < 4; k++) begin m_b13[k] = 0; m_b14[k] = 0; m_sb[k] = 0; end
    m_sf = 0; m_cp = 32'h0000_00D3;
  endtask

  task automatic m_step();
    int c = cls(m_cp[4:0]);
    int t = cls(exc_mode);
    bit pv = (c != 0) || (m_cp[4:0] == 5'h1F);
    if (exc_req && t != 0) begin
      if (t == 1) begin m_f[6] = m_u[15] + 4; m_sf = m_cp; end
      else begin m_b14[t-2] = m_u[15] + 4; m_sb[t-2] = m_cp; end
      m_cp = {m_cp[31:8], 1'b1, m_cp[6] | (t == 1), m_cp[5], exc_mode};
      m_u[15] = exc_vector;
    end else begin
      logic [31:0] sv = m_saved();
      int i = int'(wr_idx);
      if (wr_en) begin
        if (c == 1 && i >= 8 && i <= 14) m_f[i-8] = wr_data;
        else if (c >= 2 && i == 13) m_b13[c-2] = wr_data;
        else if (c >= 2 && i == 14) m_b14[c-2] = wr_data;
        else m_u[i] = wr_data;
      end
      if (ret_req) begin
        if (c != 0) m_cp = sv;
      end else if (sr_wr_en) begin
        m_cp = pv ? sr_wr_data : {sr_wr_data[31:27], m_cp[26:0]};
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    #1;
    chk(tag, rd_a_data, m_read(int'(rd_a_idx)));
    chk(tag, rd_b_data, m_read(int'(rd_b_idx)));
    chk(tag, status_out, m_cp);
    chk({tag, " R7"}, saved_status_out, m_saved());
    chk(tag, pc_out, m_u[15]);
    chk({tag, " R10"}, {31'd0, mode_err}, {31'd0, m_err()});
    @(posedge clk);
    m_step();
    @(negedge clk);
    wr_en = 0; sr_wr_en = 0; exc_req = 0; ret_req = 0;
  endtask

  task automatic wr(input int i, input logic [31:0] d, input string tag);
    wr_en = 1; wr_idx = 4'(i); wr_data = d; cyc(tag);
  endtask

  task automatic srw(input logic [31:0] d, input string tag);
    sr_wr_en = 1; sr_wr_data = d; cyc(tag);
  endtask

  task automatic exc(input logic [4:0] m, input logic [31:0] v, input string tag);
    exc_req = 1; exc_mode = m; exc_vector = v; cyc(tag);
  endtask

  task automatic rd(input int a, input int b, input string tag);
    rd_a_idx = 4'(a); rd_b_idx = 4'(b); cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [8];
    int unsigned seed;
    modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};
    m_reset();
    repeat (3) @(negedge clk);
    rd_a_idx = 13; rd_b_idx = 15;
    #1;
    chk("R1 status", status_out, 32'h0000_00D3);
    chk("R1 pc", pc_out, 0);
    chk("R1 reg", rd_a_data, 0);
    chk("R1 err", {31'd0, mode_err}, 0);
    @(negedge clk);
    rst_n = 1;

    // R2 banking of R13 between supervisor and system
    wr(13, 32'hA5A5_0013, "R3 svc write");
    srw(32'h0000_00DF, "R9 priv to sys");
    rd(13, 14, "R2 sys sees shared");
    chk("R2 sys r13", rd_a_data, 32'h0);
    for (int k = 8; k <= 14; k++) wr(k, 32'h1000_0000 + k, "R3 shared write");
    srw(32'h0000_00D1, "R9 to fiq");
    rd(8, 12, "R2 fiq private");
    chk("R2 fiq r8", rd_a_data, 32'h0);
    wr(9, 32'hF1F1_0009, "R3 fiq write");
    rd(9, 7, "R2 fiq read");
    chk("R2 fiq r9", rd_a_data, 32'hF1F1_0009);
    srw(32'h0000_0010, "R9 to user");
    rd(9, 13, "R2 user shared");
    chk("R2 user r9", rd_a_data, 32'h1000_0009);

    // R4 exception into IRQ from user
    wr(15, 32'h0000_0100, "R3 pc write");
    rd_a_idx = 14; rd_b_idx = 15;
    exc(5'h12, 32'h0000_0018, "R4 irq entry");
    chk("R4 lr", rd_a_data, 32'h0000_0104);
    chk("R4 pc", pc_out, 32'h0000_0018);
    chk("R4 status", status_out, 32'h0000_0092);
    chk("R5 f kept", {31'd0, status_out[6]}, 0);
    chk("R4 saved", saved_status_out, 32'h0000_0010);
    ret_req = 1; cyc("R7 restore");
    chk("R7 status", status_out, 32'h0000_0010);
    ret_req = 1; sr_wr_en = 1; sr_wr_data = 32'h0000_001F; cyc("R8 user return");
    chk("R8 status", status_out, 32'h0000_0010);
    srw(32'hF800_00DF, "R9 user flags");
    chk("R9 flags only", status_out, 32'hF800_0010);

    // R5 FIQ entry and R6 rejected target
    exc(5'h11, 32'h0000_001C, "R5 fiq entry");
    chk("R5 f set", {31'd0, status_out[6]}, 1);
    chk("R5 flags kept", {27'd0, status_out[31:27]}, 32'h1F);
    exc(5'h1F, 32'h0000_0040, "R6 sys target");
    chk("R6 pc", pc_out, 32'h0000_001C);
    exc(5'h07, 32'h0000_0044, "R6 unlisted target");
    chk("R6 status", status_out[4:0], 5'h11);

    // R3 write dropped during entry
    wr_en = 1; wr_idx = 4'd3; wr_data = 32'hDEAD_0003;
    exc(5'h13, 32'h0000_0008, "R3 write vs entry");
    rd(3, 14, "R3 dropped");
    chk("R3 r3", rd_a_data, 32'h0);

    // R10 unlisted mode
    srw(32'h0000_00C5, "R10 to unlisted");
    rd(13, 9, "R10 user map");
    chk("R10 err", {31'd0, mode_err}, 1);
    ret_req = 1; cyc("R8 unlisted return");
    chk("R8 unlisted", status_out, 32'h0000_00C5);
    exc(5'h17, 32'h0000_000C, "R4 abort entry");
    chk("R10 cleared", {31'd0, mode_err}, 0);

    // random mix
    seed = 32'd1234;
    void'($urandom(seed));
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      rd_a_idx = 4'($urandom_range(0, 15));
      rd_b_idx = 4'($urandom_range(0, 15));
      wr_en = ($urandom_range(0, 1) == 1);
      wr_idx = 4'($urandom_range(0, 15));
      wr_data = $urandom();
      if (r < 6) begin
        exc_req = 1; exc_mode = modes[$urandom_range(0, 7)]; exc_vector = {$urandom_range(0, 255), 2'b00};
      end
      if (r >= 6 && r < 12) ret_req = 1;
      if (r >= 10 && r < 18) begin
        sr_wr_en = 1; sr_wr_data = {$urandom_range(0, 31), 19'd0, 3'($urandom_range(0, 7)), modes[$urandom_range(0, 7)]};
      end
      cyc("R2 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule